// File: doc/BRIEF.md
# Mixed-Width Byte FIFO Data Port

This block is the data window of a memory card host controller. The processor sees one 16-bit register through which it sends and collects data. Behind the register sit two byte-wide queues: one for data going out to the card and one for data coming back from it. A 16-bit access moves two bytes and an 8-bit access moves one. Wide and narrow accesses may be freely interleaved, and the byte stream is never realigned. In a 16-bit access the upper half always corresponds to the earlier byte of the stream.

The card side sees two plain byte streams, each with a valid/ready handshake that carries one byte per beat. Illegal processor accesses are discarded and recorded in sticky flags. These are an 8-bit access at the odd byte address, a write that does not fit, and a read with too few bytes. Each flag is cleared by writing 1 to its clear bit. A synchronous clear input empties both queues in one cycle.

Top module: `mixed_width_byte_port`

## Requirements
- R1: After reset, both queues are empty, both counts are 0 and all three error flags are 0. A cycle with `fifo_clr` high leaves both counts at 0 on the following cycle.
- R2: A legal 16-bit write pushes `cpu_wdata[15:8]` first and `cpu_wdata[7:0]` second. The card receives the bytes on `tx_data` in that order.
- R3: A legal 8-bit write (`cpu_wide`=0, `cpu_odd`=0) pushes exactly one byte, `cpu_wdata[7:0]`.
- R4: A legal 16-bit read pops two bytes. `cpu_rdata[15:8]` holds the first byte popped and `cpu_rdata[7:0]` holds the second. The data is valid combinationally in the access cycle.
- R5: A legal 8-bit read pops exactly one byte. It returns that byte on `cpu_rdata[7:0]` and zero on `cpu_rdata[15:8]`.
- R6: Wide and narrow accesses in any mix keep strict byte order. Writing word 0x0123, byte 0x45, word 0x6789 and byte 0xAB sends 01,23,45,67,89,AB. Receiving that stream and then reading byte, word, byte, word returns 0x0001, 0x2345, 0x0067 and 0x89AB.
- R7: An 8-bit access with `cpu_odd`=1 pushes and pops nothing and reads as 0x0000. It sets the access flag `acc_err`. `cpu_odd` is ignored for 16-bit accesses.
- R8: A write that does not fit is dropped entirely and sets `ovf_err`. This is a 16-bit write with fewer than 2 free bytes, or an 8-bit write to a full queue.
- R9: A read with too few stored bytes pops nothing, reads as 0x0000 and sets `udf_err`. This is a 16-bit read with fewer than 2 stored bytes, or an 8-bit read from an empty queue.
- R10: The error flags are sticky. Bit 0 of `flag_clr` clears `acc_err`, bit 1 clears `ovf_err` and bit 2 clears `udf_err`. A flag that is set and cleared in the same cycle ends up set.
- R11: `tx_count`/`rx_count` give the stored bytes (0 to DEPTH). The `*_full` outputs are high at DEPTH bytes and the `*_empty` outputs are high at 0 bytes.
- R12: `tx_valid` is high whenever the transmit queue holds a byte. A byte leaves on a cycle with `tx_valid` and `tx_ready` both high, and `tx_valid`/`tx_data` hold while the card stalls. `rx_ready` is high whenever the receive queue is not full, and a byte is taken on a cycle with `rx_valid` and `rx_ready` both high.
- R13: A processor access or card beat in the same cycle as `fifo_clr` is discarded and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Synchronous clear of both queues |
| cpu_req | input | 1 | Register access strobe, one access per cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wide | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| cpu_odd | input | 1 | Byte address bit 0 of the access |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data, valid during a read access |
| flag_clr | input | 3 | Write-1-to-clear for the error flags |
| acc_err | output | 1 | Sticky illegal-address flag |
| ovf_err | output | 1 | Sticky write-overflow flag |
| udf_err | output | 1 | Sticky read-underflow flag |
| tx_valid | output | 1 | Transmit byte available to the card |
| tx_ready | input | 1 | Card accepts the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Card offers a receive byte |
| rx_ready | output | 1 | Receive queue can accept a byte |
| rx_data | input | 8 | Receive byte |
| tx_count | output | CNT_W | Bytes held in the transmit queue |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_count | output | CNT_W | Bytes held in the receive queue |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |

## Verification
The bench aims at the places where byte order can slip:
- wide and narrow accesses alternating, where a packing error would swap or duplicate the halves;
- the pointer wrap, where the second byte of a pair lands on the far side of the array.

It then works the exact free and stored limits: one free byte for a 16-bit write, and one stored byte for a 16-bit read. A design that did a partial transfer at these limits would leave a count off by one and raise no flag. A further set of cases covers:
- odd-address byte accesses;
- a flag set and cleared in the same cycle;
- a clear colliding with traffic.

These would show a design that still popped on an illegal access, lost a flag or let a beat slip through a clear. A long pseudo-random mix of all operations is compared cycle by cycle against a queue model.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;

   // how many bytes move through a queue port in one cycle
   typedef enum logic [1:0] {
      XFER_NONE = 2'd0,
      XFER_ONE  = 2'd1,
      XFER_TWO  = 2'd2
   } xfer_t;

   // error events; acc in bit 0, ovf in bit 1, udf in bit 2
   typedef struct packed {
      logic udf;
      logic ovf;
      logic acc;
   } err_evt_t;

   localparam int ERR_N = 3;

endpackage

// File: rtl/bfp_byte_fifo.sv
module bfp_byte_fifo
   import bfp_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  xfer_t             push_n,
   input  logic [BYTE_W-1:0] push_d0,
   input  logic [BYTE_W-1:0] push_d1,
   input  xfer_t             pop_n,
   output logic [BYTE_W-1:0] head0,
   output logic [BYTE_W-1:0] head1,
   output logic [CNT_W-1:0]  count,
   output logic              full,
   output logic              empty
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("bfp_byte_fifo: DEPTH must be a power of two and at least 2");
   end

   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_ptr1, rd_ptr1;
   logic [CNT_W-1:0]  push_cnt, pop_cnt;
   logic              we0, we1;
   logic [BYTE_W-1:0] cells [DEPTH];

   assign push_cnt = CNT_W'(push_n);
   assign pop_cnt  = CNT_W'(pop_n);
   assign we0      = !clr && (push_n != XFER_NONE);
   assign we1      = !clr && (push_n == XFER_TWO);
   assign wr_ptr1  = wr_ptr + 1'b1;
   assign rd_ptr1  = rd_ptr + 1'b1;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      logic [BYTE_W-1:0] cell_q;
      always_ff @(posedge clk) begin
         if (we0 && wr_ptr == PTR_W'(i)) begin
            cell_q <= push_d0;
         end else if (we1 && wr_ptr1 == PTR_W'(i)) begin
            cell_q <= push_d1;
         end
      end
      assign cells[i] = cell_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + PTR_W'(push_cnt);
         rd_ptr <= rd_ptr + PTR_W'(pop_cnt);
         count  <= count + push_cnt - pop_cnt;
      end
   end

   assign head0 = cells[rd_ptr];
   assign head1 = cells[rd_ptr1];
   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);

   // R8: the decoder never asks for more bytes than there is room for
   p_push_fits_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> push_cnt <= CNT_W'(DEPTH) - count);

   // R9: the decoder never pops more bytes than are stored
   p_pop_avail_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !clr |-> pop_cnt <= count);

   // R1: a clear leaves the queue empty on the next cycle
   p_clr_empties_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty && count == '0);

   // R11: occupancy stays within the array
   p_count_bound_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

endmodule

// File: rtl/bfp_access_decode.sv
module bfp_access_decode
   import bfp_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             cpu_req,
   input  logic             cpu_we,
   input  logic             cpu_wide,
   input  logic             cpu_odd,
   input  logic             fifo_clr,
   input  logic [CNT_W-1:0] tx_count,
   input  logic [CNT_W-1:0] rx_count,
   output xfer_t            tx_push_n,
   output xfer_t            rx_pop_n,
   output err_evt_t         evt
);

   logic             legal, wr_go, rd_go;
   logic [CNT_W-1:0] need, tx_free;

   always_comb begin
      need      = cpu_wide ? CNT_W'(2) : CNT_W'(1);
      tx_free   = CNT_W'(DEPTH) - tx_count;
      legal     = cpu_wide || !cpu_odd;
      wr_go     = cpu_req && cpu_we && !fifo_clr;
      rd_go     = cpu_req && !cpu_we && !fifo_clr;
      evt       = '0;
      evt.acc   = (wr_go || rd_go) && !legal;
      evt.ovf   = wr_go && legal && (tx_free < need);
      evt.udf   = rd_go && legal && (rx_count < need);
      tx_push_n = XFER_NONE;
      rx_pop_n  = XFER_NONE;
      if (wr_go && legal && !evt.ovf) begin
         tx_push_n = cpu_wide ? XFER_TWO : XFER_ONE;
      end
      if (rd_go && legal && !evt.udf) begin
         rx_pop_n = cpu_wide ? XFER_TWO : XFER_ONE;
      end
   end

endmodule

// File: rtl/bfp_err_sticky.sv
module bfp_err_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] w1c,
   output logic [N-1:0] q
);

   if (N < 1) begin : g_bad_n
      $error("bfp_err_sticky: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q <= 1'b0;
         end else if (set[i]) begin
            flag_q <= 1'b1;
         end else if (w1c[i]) begin
            flag_q <= 1'b0;
         end
      end
      assign q[i] = flag_q;

      // R10: a flag stays up until its clear bit is written
      p_flag_sticky_r10 : assert property (@(posedge clk) disable iff (!rst_n)
         flag_q && !w1c[i] |=> flag_q);

      // R10: an event wins over a simultaneous clear
      p_set_wins_r10 : assert property (@(posedge clk) disable iff (!rst_n)
         set[i] && w1c[i] |=> flag_q);
   end

endmodule

// File: rtl/mixed_width_byte_port.sv
module mixed_width_byte_port
   import bfp_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fifo_clr,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic              cpu_wide,
   input  logic              cpu_odd,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   input  logic [ERR_N-1:0]  flag_clr,
   output logic              acc_err,
   output logic              ovf_err,
   output logic              udf_err,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [BYTE_W-1:0] tx_data,
   input  logic              rx_valid,
   output logic              rx_ready,
   input  logic [BYTE_W-1:0] rx_data,
   output logic [CNT_W-1:0]  tx_count,
   output logic              tx_full,
   output logic              tx_empty,
   output logic [CNT_W-1:0]  rx_count,
   output logic              rx_full,
   output logic              rx_empty
);

   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("mixed_width_byte_port: register must hold exactly two bytes");
   end

   xfer_t             tx_push_n, rx_pop_n, tx_pop_n, rx_push_n;
   err_evt_t          evt;
   logic [ERR_N-1:0]  flags;
   logic [BYTE_W-1:0] tx_head1, rx_head0, rx_head1;
   logic [BYTE_W-1:0] tx_d0;

   bfp_access_decode #(.DEPTH(DEPTH)) u_decode (
      .cpu_req   (cpu_req),
      .cpu_we    (cpu_we),
      .cpu_wide  (cpu_wide),
      .cpu_odd   (cpu_odd),
      .fifo_clr  (fifo_clr),
      .tx_count  (tx_count),
      .rx_count  (rx_count),
      .tx_push_n (tx_push_n),
      .rx_pop_n  (rx_pop_n),
      .evt       (evt)
   );

   // upper byte goes first for a wide write, the low byte for a narrow one
   assign tx_d0     = cpu_wide ? cpu_wdata[WORD_W-1:BYTE_W] : cpu_wdata[BYTE_W-1:0];
   assign tx_valid  = !tx_empty;
   assign tx_pop_n  = (tx_valid && tx_ready) ? XFER_ONE : XFER_NONE;
   assign rx_ready  = !rx_full;
   assign rx_push_n = (rx_valid && rx_ready) ? XFER_ONE : XFER_NONE;

   bfp_byte_fifo #(.DEPTH(DEPTH)) u_tx_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fifo_clr),
      .push_n  (tx_push_n),
      .push_d0 (tx_d0),
      .push_d1 (cpu_wdata[BYTE_W-1:0]),
      .pop_n   (tx_pop_n),
      .head0   (tx_data),
      .head1   (tx_head1),
      .count   (tx_count),
      .full    (tx_full),
      .empty   (tx_empty)
   );

   bfp_byte_fifo #(.DEPTH(DEPTH)) u_rx_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (fifo_clr),
      .push_n  (rx_push_n),
      .push_d0 (rx_data),
      .push_d1 (rx_data),
      .pop_n   (rx_pop_n),
      .head0   (rx_head0),
      .head1   (rx_head1),
      .count   (rx_count),
      .full    (rx_full),
      .empty   (rx_empty)
   );

   // read unpacking: first popped byte lands in the upper half of a word
   always_comb begin
      unique case (rx_pop_n)
         XFER_TWO: cpu_rdata = {rx_head0, rx_head1};
         XFER_ONE: cpu_rdata = {{BYTE_W{1'b0}}, rx_head0};
         default:  cpu_rdata = '0;
      endcase
   end

   bfp_err_sticky #(.N(ERR_N)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (evt),
      .w1c   (flag_clr),
      .q     (flags)
   );

   assign acc_err = flags[0];
   assign ovf_err = flags[1];
   assign udf_err = flags[2];

   // R12: a stalled transmit byte stays offered and unchanged
   p_tx_hold_r12 : assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready && !fifo_clr |=> tx_valid && $stable(tx_data));

   // R4: a legal wide read with no card beat drops the count by two
   p_word_pop_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we && cpu_wide && !fifo_clr && rx_count >= CNT_W'(2)
      && !(rx_valid && rx_ready)
      |=> rx_count == $past(rx_count) - CNT_W'(2));

   // R7: an odd byte read leaves the receive queue alone
   p_odd_no_pop_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      cpu_req && !cpu_we && !cpu_wide && cpu_odd && !fifo_clr
      && !(rx_valid && rx_ready)
      |=> $stable(rx_count));

   // R13: a clear wins over any concurrent traffic
   p_clr_wins_r13 : assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> tx_count == '0 && rx_count == '0);

endmodule

// File: tb/mixed_width_byte_port_bench.sv
module mixed_width_byte_port_bench;

   localparam int DEPTH = 16;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic fifo_clr = 1'b0;
   logic cpu_req = 1'b0, cpu_we = 1'b0, cpu_wide = 1'b0, cpu_odd = 1'b0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic [2:0]  flag_clr = '0;
   logic acc_err, ovf_err, udf_err;
   logic tx_valid, tx_ready = 1'b0;
   logic [7:0] tx_data;
   logic rx_valid = 1'b0, rx_ready;
   logic [7:0] rx_data = '0;
   logic [CNT_W-1:0] tx_count, rx_count;
   logic tx_full, tx_empty, rx_full, rx_empty;

   always #5 clk = ~clk;

   mixed_width_byte_port #(.DEPTH(DEPTH)) u_mixed_width_byte_port (
      .clk, .rst_n, .fifo_clr, .cpu_req, .cpu_we, .cpu_wide, .cpu_odd,
      .cpu_wdata, .cpu_rdata, .flag_clr, .acc_err, .ovf_err, .udf_err,
      .tx_valid, .tx_ready, .tx_data, .rx_valid, .rx_ready, .rx_data,
      .tx_count, .tx_full, .tx_empty, .rx_count, .rx_full, .rx_empty
   );

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   logic [15:0] s_rdata;
   logic        s_txv, s_rxr;
   logic [7:0]  s_txd;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one clock: drive at the falling edge, sample combinational outputs,
   // then let the rising edge act and settle
   task automatic step(input logic req, input logic we, input logic wide,
                       input logic odd, input logic [15:0] wd,
                       input logic rv, input logic [7:0] rd, input logic tr,
                       input logic fc, input logic [2:0] ec);
      @(negedge clk);
      cpu_req = req; cpu_we = we; cpu_wide = wide; cpu_odd = odd;
      cpu_wdata = wd; rx_valid = rv; rx_data = rd; tx_ready = tr;
      fifo_clr = fc; flag_clr = ec;
      #2;
      s_rdata = cpu_rdata; s_txv = tx_valid; s_txd = tx_data; s_rxr = rx_ready;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 16'h0, 0, 8'h0, 0, 0, 3'b0);
   endtask
   task automatic wr_w(input logic [15:0] d);
      step(1, 1, 1, 0, d, 0, 8'h0, 0, 0, 3'b0);
   endtask
   task automatic wr_b(input logic [7:0] d, input logic odd);
      step(1, 1, 0, odd, {8'h5A, d}, 0, 8'h0, 0, 0, 3'b0);
   endtask
   task automatic rd_w();
      step(1, 0, 1, 0, 16'h0, 0, 8'h0, 0, 0, 3'b0);
   endtask
   task automatic rd_b(input logic odd);
      step(1, 0, 0, odd, 16'h0, 0, 8'h0, 0, 0, 3'b0);
   endtask
   task automatic give(input logic [7:0] b);
      step(0, 0, 0, 0, 16'h0, 1, b, 0, 0, 3'b0);
   endtask
   task automatic take(input string tag, input logic [7:0] exp);
      step(0, 0, 0, 0, 16'h0, 0, 8'h0, 1, 0, 3'b0);
      chk({tag, " tx_valid"}, 32'(s_txv), 32'd1);
      chk({tag, " tx_data"}, 32'(s_txd), 32'(exp));
   endtask
   task automatic clr_flags();
      step(0, 0, 0, 0, 16'h0, 0, 8'h0, 0, 0, 3'b111);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] txq[$];
      logic [7:0] rxq[$];
      logic [2:0] fl;
      logic [15:0] lfsr;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // ---- R1 / R11 / R12: reset state
      idle();
      chk("R1 tx_count", 32'(tx_count), 0);
      chk("R1 rx_count", 32'(rx_count), 0);
      chk("R1 flags", 32'({udf_err, ovf_err, acc_err}), 0);
      chk("R11 tx_empty", 32'(tx_empty), 1);
      chk("R11 rx_full", 32'(rx_full), 0);
      chk("R12 tx_valid idle", 32'(s_txv), 0);
      chk("R12 rx_ready idle", 32'(s_rxr), 1);

      // ---- R6 / R2 / R3: mixed write order
      wr_w(16'h0123); wr_b(8'h45, 0); wr_w(16'h6789); wr_b(8'hAB, 0);
      chk("R6 tx_count", 32'(tx_count), 6);
      take("R2 b0", 8'h01); take("R2 b1", 8'h23); take("R3 b2", 8'h45);
      take("R6 b3", 8'h67); take("R6 b4", 8'h89); take("R3 b5", 8'hAB);
      chk("R11 tx_empty after drain", 32'(tx_empty), 1);

      // ---- R4 / R5 / R6: mixed read order
      give(8'h01); give(8'h23); give(8'h45); give(8'h67); give(8'h89); give(8'hAB);
      chk("R12 rx_count", 32'(rx_count), 6);
      rd_b(0); chk("R5 byte read", 32'(s_rdata), 32'h0001);
      rd_w();  chk("R4 word read", 32'(s_rdata), 32'h2345);
      rd_b(0); chk("R6 byte read", 32'(s_rdata), 32'h0067);
      rd_w();  chk("R6 word read", 32'(s_rdata), 32'h89AB);
      chk("R11 rx_empty", 32'(rx_empty), 1);

      // ---- R7: odd byte accesses ignored
      wr_b(8'h55, 1);
      chk("R7 odd write count", 32'(tx_count), 0);
      chk("R7 acc_err", 32'(acc_err), 1);
      give(8'h77);
      rd_b(1);
      chk("R7 odd read data", 32'(s_rdata), 0);
      chk("R7 odd read count", 32'(rx_count), 1);
      idle(); idle();
      chk("R10 acc_err sticky", 32'(acc_err), 1);
      step(0, 0, 0, 0, 16'h0, 0, 8'h0, 0, 0, 3'b001);
      chk("R10 acc_err cleared", 32'(acc_err), 0);
      rd_b(0); chk("R7 byte after odd", 32'(s_rdata), 32'h0077);

      // ---- R9: underflow
      rd_b(0);
      chk("R9 empty byte read data", 32'(s_rdata), 0);
      chk("R9 udf_err", 32'(udf_err), 1);
      give(8'h11);
      rd_w();
      chk("R9 short word read data", 32'(s_rdata), 0);
      chk("R9 short word read count", 32'(rx_count), 1);
      rd_b(0); chk("R9 remaining byte", 32'(s_rdata), 32'h0011);
      chk("R10 udf_err sticky", 32'(udf_err), 1);

      // ---- R8 / R11: overflow at the exact free limits
      for (int i = 0; i < 8; i++) wr_w({8'(2 * i), 8'(2 * i + 1)});
      chk("R11 tx_full", 32'(tx_full), 1);
      chk("R11 tx_count full", 32'(tx_count), 16);
      chk("R8 ovf before", 32'(ovf_err), 0);
      wr_w(16'hDEAD);
      chk("R8 ovf_err", 32'(ovf_err), 1);
      chk("R8 count kept", 32'(tx_count), 16);
      take("R2 first of full", 8'h00);
      wr_w(16'hFFFF);
      chk("R8 one free word write dropped", 32'(tx_count), 15);
      wr_b(8'hEE, 0);
      chk("R8 byte fits last slot", 32'(tx_count), 16);
      for (int i = 1; i < 16; i++) take("R2 wrap order", 8'(i));
      take("R3 wrap last", 8'hEE);

      // ---- R10: set wins over clear
      clr_flags();
      chk("R10 all cleared", 32'({udf_err, ovf_err, acc_err}), 0);
      step(1, 1, 0, 1, 16'h0, 0, 8'h0, 0, 0, 3'b001);
      chk("R10 set wins", 32'(acc_err), 1);
      clr_flags();

      // ---- R12: receive side full
      for (int i = 0; i < 16; i++) give(8'(8'h80 + i));
      chk("R11 rx_full", 32'(rx_full), 1);
      give(8'hCC);
      chk("R12 rx_ready low when full", 32'(s_rxr), 0);
      chk("R12 full rx not pushed", 32'(rx_count), 16);
      rd_w(); chk("R4 word from full", 32'(s_rdata), 32'h8081);

      // ---- R1 / R13: clear with concurrent traffic
      wr_w(16'hA1A2);
      step(1, 1, 1, 0, 16'hB1B2, 1, 8'hC3, 1, 1, 3'b0);
      chk("R13 tx cleared", 32'(tx_count), 0);
      chk("R13 rx cleared", 32'(rx_count), 0);
      chk("R13 no flag", 32'({udf_err, ovf_err, acc_err}), 0);
      idle();
      chk("R1 empty after clear", 32'({tx_empty, rx_empty}), 3);

      // ---- sweep against a queue model
      fl = '0;
      lfsr = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
         logic [2:0]  op;
         logic        odd, fc;
         logic [2:0]  ec;
         logic [15:0] wd, exp_rd;
         logic [2:0]  ev;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         op  = lfsr[2:0];
         odd = (op == 3'd0 || op == 3'd2) ? lfsr[3] : (lfsr[3] & lfsr[4]);
         ec  = (lfsr[9] & lfsr[10]) ? lfsr[7:5] : 3'b0;
         fc  = (lfsr[15:11] == 5'd0);
         wd  = {lfsr[7:0] ^ 8'(n), lfsr[15:8]};
         exp_rd = '0;
         ev = '0;
         case (op)
            3'd0: step(1, 1, 1, odd, wd, 0, 8'h0, 0, fc, ec);
            3'd1: step(1, 1, 0, odd, wd, 0, 8'h0, 0, fc, ec);
            3'd2: step(1, 0, 1, odd, wd, 0, 8'h0, 0, fc, ec);
            3'd3: step(1, 0, 0, odd, wd, 0, 8'h0, 0, fc, ec);
            3'd4, 3'd5: step(0, 0, 0, 0, wd, 1, wd[7:0], 0, fc, ec);
            default: step(0, 0, 0, 0, wd, 0, 8'h0, 1, fc, ec);
         endcase
         if (fc) begin
            txq.delete();
            rxq.delete();
         end else begin
            case (op)
               3'd0: if (txq.size() <= DEPTH - 2) begin
                        txq.push_back(wd[15:8]); txq.push_back(wd[7:0]);
                     end else ev[1] = 1'b1;
               3'd1: if (odd) ev[0] = 1'b1;
                     else if (txq.size() < DEPTH) txq.push_back(wd[7:0]);
                     else ev[1] = 1'b1;
               3'd2: if (rxq.size() >= 2) begin
                        exp_rd[15:8] = rxq.pop_front();
                        exp_rd[7:0]  = rxq.pop_front();
                     end else ev[2] = 1'b1;
               3'd3: if (odd) ev[0] = 1'b1;
                     else if (rxq.size() >= 1) exp_rd = {8'h00, rxq.pop_front()};
                     else ev[2] = 1'b1;
               3'd4, 3'd5: begin
                  chk("R12 sweep rx_ready", 32'(s_rxr), 32'(rxq.size() < DEPTH));
                  if (rxq.size() < DEPTH) rxq.push_back(wd[7:0]);
               end
               default: begin
                  chk("R12 sweep tx_valid", 32'(s_txv), 32'(txq.size() > 0));
                  if (txq.size() > 0) chk("R2 sweep tx_data", 32'(s_txd), 32'(txq.pop_front()));
               end
            endcase
            if (op == 3'd2 || op == 3'd3)
               chk("R5 sweep rdata", 32'(s_rdata), 32'(exp_rd));
         end
         fl = (fl & ~ec) | ev;
         chk("R11 sweep tx_count", 32'(tx_count), 32'(txq.size()));
         chk("R11 sweep rx_count", 32'(rx_count), 32'(rxq.size()));
         chk("R10 sweep flags", 32'({udf_err, ovf_err, acc_err}), 32'(fl));
         chk("R11 sweep full/empty", 32'({tx_full, tx_empty, rx_full, rx_empty}),
             32'({txq.size() == DEPTH, txq.size() == 0, rxq.size() == DEPTH, rxq.size() == 0}));
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule